// File: doc/BRIEF.md
# Sequenced-Pulse Segmented Shift Register

This block is a long serial shift register, 256 data bits by default, split into short segments of four bits each. Every segment has its own data stages plus one extra holding stage. The holding stage carries the segment's outgoing bit across the boundary into the next segment. Each stage is level-enabled: it only takes a new value while its own enable pulse is high. All segments share one sequencer, which produces the enable pulses in common.

A request to shift starts a sequence of non-overlapping one-cycle pulses:

- The holding pulse comes first. It copies each segment's last data bit into its holding stage.
- The data positions follow, from the last position down to the first.
- The first position of each segment loads the previous segment's holding stage. For the first segment it loads the serial input.

Because of this order, no stage is ever written while the stage feeding it is also enabled.

The sequencer has three named states:

- `SQ_IDLE`: waiting for a request.
- `SQ_HOLD`: the holding-stage pulse.
- `SQ_DATA`: the data pulses, with a position counter that counts down.

It has four named transitions:

- `T_START`: from `SQ_IDLE` to `SQ_HOLD` on a request.
- `T_OPEN`: from `SQ_HOLD` to `SQ_DATA`, with the counter set to the last position.
- `T_STEP`: from `SQ_DATA` to `SQ_DATA` while the counter is above zero, decrementing it.
- `T_DONE`: from `SQ_DATA` to `SQ_IDLE` once position zero has been pulsed.

The whole contents are brought out in parallel for observation.

Top module: `seg_shift_reg`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every data and holding stage to 0 and returns the sequencer to idle. After that edge `busy` is 0, `par_out` is all zeros and `serial_out` is 0.
- R2: A `shift_req` that is sampled high while idle starts a shift. `busy` is 1 from the next cycle for exactly SEG_W+1 consecutive cycles (5 by default), then returns to 0.
- R3: At most one stage enable pulse is active in any cycle. The holding pulse comes first, then the data positions from SEG_W-1 down to 0.
- R4: While idle, `par_out` does not change.
- R5: When a shift completes, `par_out[i]` equals its value before the shift at index i-1, for every i from 1 to TOTAL-1. This includes bits that cross segment boundaries.
- R6: `par_out[0]` after a shift equals `serial_in` as sampled at the last clock edge of that shift. The serial input must be held steady while `busy` is high.
- R7: A `shift_req` sampled while `busy` is 1 is ignored. No extra shift follows, and the contents stay as if the request had not come.
- R8: `serial_out` is the last stage of the final segment. After N completed shifts since reset, it carries the bit applied at shift N-(TOTAL-1) when N ≥ TOTAL, and 0 otherwise.
- R9: Bit numbering of `par_out` is as follows. Bit s*SEG_W+p is data position p of segment s. Segment 0 is the one fed by `serial_in`, and position 0 is a segment's first stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| shift_req | input | 1 | Request one shift by one position |
| serial_in | input | 1 | Bit entering the first stage |
| serial_out | output | 1 | Last stage of the final segment |
| busy | output | 1 | High while a shift sequence runs |
| par_out | output | NUM_SEG*SEG_W | Full register contents, bit 0 newest |

## Verification
A sequencer stuck in a state, or one that skips or repeats a pulse, shows at once as a `busy` window that is not five cycles long. It also shows as a `par_out` that disagrees with an ideal shift register after the very next completed shift.

A holding stage loaded in the wrong order duplicates or drops the bit at a segment boundary. That difference is visible in `par_out` after the same shift. It reaches `serial_out` only after the bit has travelled to the end.

A request that leaks through while busy shows as an extra `busy` window in the cycle after completion.

// File: rtl/seg_shift_pkg.sv
package seg_shift_pkg;

    // Sequencer states for the pulse generator.
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_HOLD = 2'd1,
        SQ_DATA = 2'd2
    } sq_state_t;

endpackage

// File: rtl/pulse_seq.sv
module pulse_seq
    import seg_shift_pkg::*;
#(
    parameter int SEG_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_req,
    output logic             pulse_hold,
    output logic [SEG_W-1:0] pulse_data,
    output logic             busy
);
    localparam int POS_W = (SEG_W > 1) ? $clog2(SEG_W) : 1;
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(SEG_W - 1);

    sq_state_t        state, state_nxt;
    logic [POS_W-1:0] pos, pos_nxt;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            pos   <= '0;
        end else begin
            state <= state_nxt;
            pos   <= pos_nxt;
        end
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        pos_nxt   = pos;
        unique case (state)
            SQ_IDLE: begin
                if (shift_req) state_nxt = SQ_HOLD;    // T_START
            end
            SQ_HOLD: begin
                state_nxt = SQ_DATA;                   // T_OPEN
                pos_nxt   = LAST_POS;
            end
            SQ_DATA: begin
                if (pos == '0) begin
                    state_nxt = SQ_IDLE;               // T_DONE
                end else begin
                    pos_nxt   = pos - 1'b1;            // T_STEP
                end
            end
            default: state_nxt = SQ_IDLE;
        endcase
    end

    // Outputs: one pulse per cycle at most
    always_comb begin
        pulse_hold = 1'b0;
        pulse_data = '0;
        busy       = 1'b1;
        unique case (state)
            SQ_IDLE: busy = 1'b0;
            SQ_HOLD: pulse_hold = 1'b1;
            SQ_DATA: pulse_data[pos] = 1'b1;
            default: busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/seg_unit.sv
module seg_unit #(
    parameter int SEG_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             seg_in,
    input  logic             pulse_hold,
    input  logic [SEG_W-1:0] pulse_data,
    output logic [SEG_W-1:0] data,
    output logic             hold
);
    // Holding stage: captures the last data bit before it is overwritten.
    always_ff @(posedge clk) begin
        if (rst)             hold <= 1'b0;
        else if (pulse_hold) hold <= data[SEG_W-1];
    end

    // Data stages, each open only during its own pulse.
    generate
        for (genvar p = 0; p < SEG_W; p++) begin : g_stage
            logic d_src;
            if (p == 0) begin : g_first
                assign d_src = seg_in;
            end else begin : g_inner
                assign d_src = data[p-1];
            end
            always_ff @(posedge clk) begin
                if (rst)                data[p] <= 1'b0;
                else if (pulse_data[p]) data[p] <= d_src;
            end
        end
    endgenerate

endmodule

// File: rtl/seg_shift_reg.sv
module seg_shift_reg #(
    parameter int SEG_W   = 4,
    parameter int NUM_SEG = 64,
    localparam int TOTAL  = SEG_W * NUM_SEG
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_req,
    input  logic             serial_in,
    output logic             serial_out,
    output logic             busy,
    output logic [TOTAL-1:0] par_out
);
    logic             pulse_hold;
    logic [SEG_W-1:0] pulse_data;
    logic [NUM_SEG:0] link;

    pulse_seq #(.SEG_W(SEG_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .shift_req  (shift_req),
        .pulse_hold (pulse_hold),
        .pulse_data (pulse_data),
        .busy       (busy)
    );

    assign link[0] = serial_in;

    generate
        for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
            seg_unit #(.SEG_W(SEG_W)) u_seg (
                .clk        (clk),
                .rst        (rst),
                .seg_in     (link[s]),
                .pulse_hold (pulse_hold),
                .pulse_data (pulse_data),
                .data       (par_out[s*SEG_W +: SEG_W]),
                .hold       (link[s+1])
            );
        end
    endgenerate

    assign serial_out = par_out[TOTAL-1];

endmodule

// File: rtl/seg_shift_chk.sv
module seg_shift_chk #(
    parameter int SEG_W   = 4,
    parameter int NUM_SEG = 64,
    localparam int TOTAL  = SEG_W * NUM_SEG
) (
    input logic             clk,
    input logic             rst,
    input logic             shift_req,
    input logic             serial_in,
    input logic             busy,
    input logic [TOTAL-1:0] par_out,
    input logic             pulse_hold,
    input logic [SEG_W-1:0] pulse_data
);
    localparam int CNT_W = $clog2(SEG_W + 2) + 1;
    logic [CNT_W-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst)       busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 1'b1;
        else           busy_cnt <= '0;
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (par_out == '0 && !busy));

    a_r2_start: assert property (@(posedge clk) disable iff (rst)
        (!busy && shift_req) |=> busy);

    a_r2_window_bound: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_cnt <= CNT_W'(SEG_W)));

    a_r2_window_end: assert property (@(posedge clk) disable iff (rst)
        (busy && busy_cnt == CNT_W'(SEG_W)) |=> !busy);

    a_r3_one_pulse: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pulse_hold, pulse_data}));

    a_r3_hold_first: assert property (@(posedge clk) disable iff (rst)
        (busy && busy_cnt == '0) |-> pulse_hold);

    a_r4_idle_stable: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(par_out));

    a_r6_serial_capture: assert property (@(posedge clk) disable iff (rst)
        (busy && busy_cnt == CNT_W'(SEG_W)) |=> (par_out[0] == $past(serial_in)));

    a_r7_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy && busy_cnt == CNT_W'(SEG_W)) |=> ##1 (!busy || $past(shift_req)));

endmodule

bind seg_shift_reg seg_shift_chk #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .shift_req  (shift_req),
    .serial_in  (serial_in),
    .busy       (busy),
    .par_out    (par_out),
    .pulse_hold (pulse_hold),
    .pulse_data (pulse_data)
);

// File: tb/seg_shift_reg_bench.sv
`timescale 1ns/1ps
module seg_shift_reg_bench;
    localparam int SEG_W   = 4;
    localparam int NUM_SEG = 64;
    localparam int TOTAL   = SEG_W * NUM_SEG;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             shift_req = 1'b0;
    logic             serial_in = 1'b0;
    logic             serial_out;
    logic             busy;
    logic [TOTAL-1:0] par_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [TOTAL-1:0] ref_sr;
    bit               hist [0:1023];
    int               n_shift;
    logic [15:0]      lfsr = 16'hACE1;

    always #4 clk = ~clk;   // 125 MHz

    seg_shift_reg #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG)) u_seg_shift_reg (
        .clk        (clk),
        .rst        (rst),
        .shift_req  (shift_req),
        .serial_in  (serial_in),
        .serial_out (serial_out),
        .busy       (busy),
        .par_out    (par_out)
    );

    task automatic chk_bit(input bit ok, input string req, input logic act, input logic exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic chk_vec(input string req, input logic [TOTAL-1:0] act, input logic [TOTAL-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        chk_vec("R1 par_out cleared", par_out, '0);
        chk_bit(busy === 1'b0, "R1 busy low", busy, 1'b0);
        chk_bit(serial_out === 1'b0, "R1 serial_out low", serial_out, 1'b0);
        rst = 1'b0;
        ref_sr  = '0;
        n_shift = 0;
    endtask

    // One shift; poke=1 raises shift_req during the busy window (R7).
    task automatic do_shift(input bit b, input bit poke);
        int nb;
        @(negedge clk);
        shift_req = 1'b1;
        serial_in = b;
        @(negedge clk);
        shift_req = 1'b0;
        chk_bit(busy === 1'b1, "R2 busy after request", busy, 1'b1);
        nb = 0;
        while (busy === 1'b1 && nb < 20) begin
            nb++;
            if (poke && nb == 2) shift_req = 1'b1;
            @(negedge clk);
            shift_req = 1'b0;
        end
        chk_int("R2 busy window length", nb, SEG_W + 1);
        // Ideal flip-flop reference: R5, R6, R9
        ref_sr = {ref_sr[TOTAL-2:0], b};
        n_shift++;
        hist[n_shift % 1024] = b;
        chk_vec("R5/R6/R9 contents after shift", par_out, ref_sr);
        // R8: serial_out
        if (n_shift >= TOTAL)
            chk_bit(serial_out === hist[(n_shift - (TOTAL - 1)) % 1024],
                    "R8 serial_out history", serial_out, hist[(n_shift - (TOTAL - 1)) % 1024]);
        else
            chk_bit(serial_out === 1'b0, "R8 serial_out before fill", serial_out, 1'b0);
        // R4, R7: idle stays idle, contents unchanged
        @(negedge clk);
        chk_bit(busy === 1'b0, "R7 no extra shift", busy, 1'b0);
        chk_vec("R4 idle contents stable", par_out, ref_sr);
    endtask

    initial begin
        do_reset();
        // Pattern A: a single one walked through the whole chain (R8, R9)
        do_shift(1'b1, 1'b0);
        for (int i = 1; i < TOTAL + 4; i++) do_shift(1'b0, (i % 7) == 3);
        // Pattern B: pseudo-random bits, with requests poked while busy (R7)
        for (int i = 0; i < 120; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            do_shift(lfsr[0], (i % 3) == 0);
        end
        // Mid-run reset (R1)
        do_reset();
        // Pattern C: ones, then alternating
        for (int i = 0; i < 30; i++) do_shift(1'b1, 1'b0);
        for (int i = 0; i < 30; i++) do_shift(i[0], 1'b1);
        // Idle with no request for several cycles (R4)
        repeat (6) @(negedge clk);
        chk_vec("R4 long idle stable", par_out, ref_sr);
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule